// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

This block supervises software liveness against a free-running 64-bit system count supplied from outside. Software loads a 32-bit timeout interval and sets an enable bit. Each refresh computes a deadline: the current count plus the interval. If software misses the deadline, the block first raises a warning interrupt. It then starts a second interval of the same length. If that second deadline also passes without a refresh, the block latches a reset request. Any refresh during the warning stage withdraws the warning and restarts the first interval.

Two small register frames sit on plain memory-mapped read/write buses. Each bus has a request, a write flag, a 12-bit byte address, write data and read data. Read data is combinational from the address. A write takes effect at the clock edge where request and write are both high. There is no back-pressure: every access completes in the cycle it is presented.

The refresh frame is write-only in effect. Its data lines are not carried, because the data value of a refresh write has no meaning. The control frame holds the enable and status word, the interval, and the deadline. Both frames carry identification words. The latched reset status survives everything except the power-on reset input, so software can learn after a restart that the watchdog caused it.

Top module: `wdt2_top`

## Requirements
- R1: After power-on reset (rst_n low), the following all read 0: the control word, the interval and the deadline. The warn_irq and reset_req outputs are also low.
- R2: The 32-bit interval register at control offset 0x008 is read/write. The 64-bit deadline is read/write as two words: low word at 0x010, high word at 0x014. Writing either word sets that half of the deadline directly.
- R3: A write to refresh-frame offset 0x000 is a refresh, whatever the data. After the edge, the deadline equals the count sampled at that edge plus the zero-extended interval, and the warning status is clear.
- R4: The control word is at control offset 0x000: bit 0 is enable, bit 1 is warning status, bit 2 is reset status. A write there sets enable from data bit 0 and also performs a refresh. Data bits 1 and 2 of such a write do not change the status bits.
- R5: Stage one fires at an edge where all of the following hold: enable is 1, the warning is clear, the count is at or past the deadline, and no refresh occurs. After that edge, warn_irq is high, control bit 1 reads 1, and the deadline is reloaded to that count plus the interval.
- R6: Stage two fires at an edge where enable is 1, the warning is set, and the count is at or past the deadline. After that edge, reset_req is high and control bit 2 reads 1. With no refresh, the time from refresh to reset_req is twice the interval.
- R7: A refresh while the warning is set clears control bit 1 and drops warn_irq after that edge.
- R8: Once set, the reset status bit stays set through refreshes and enable changes. Only rst_n clears it.
- R9: While enable is 0, warn_irq and reset_req are low and neither stage can fire, whatever the count.
- R10: Both frames return the IMPL_ID parameter at offset 0xFCC and the PART_ID parameter at offset 0xFD0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| sys_cnt | input | 64 | Free-running system count |
| rf_req | input | 1 | Refresh frame access request |
| rf_we | input | 1 | Refresh frame write flag |
| rf_addr | input | 12 | Refresh frame byte address |
| rf_rdata | output | 32 | Refresh frame read data |
| cf_req | input | 1 | Control frame access request |
| cf_we | input | 1 | Control frame write flag |
| cf_addr | input | 12 | Control frame byte address |
| cf_wdata | input | 32 | Control frame write data |
| cf_rdata | output | 32 | Control frame read data |
| warn_irq | output | 1 | Stage-one warning interrupt |
| reset_req | output | 1 | Stage-two reset request |

## Verification
The deadline comparison is tried with the count one below the deadline and exactly at it, in both stages. This separates a correct at-or-past compare from an off-by-one or strict compare. It also checks that stage two lasts exactly as long as stage one. Refreshes are applied in three ways: through the refresh frame with arbitrary data, through the control word with the status bits set in the data, and by a direct deadline write. This separates true refreshes from plain register writes and shows that the status bits cannot be written. The count is also pushed far beyond the deadline with enable cleared, both before arming and after a reset request, to confirm the disable gating and that the reset status is sticky.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  localparam int FRAME_AW = 12;
  localparam logic [FRAME_AW-1:0] A_CTRL     = 12'h000;
  localparam logic [FRAME_AW-1:0] A_INTERVAL = 12'h008;
  localparam logic [FRAME_AW-1:0] A_DEADLINE = 12'h010;
  localparam logic [FRAME_AW-1:0] A_IMPL     = 12'hFCC;
  localparam logic [FRAME_AW-1:0] A_PART     = 12'hFD0;

  // control word bit positions
  localparam int B_EN   = 0;
  localparam int B_WARN = 1;
  localparam int B_RST  = 2;
endpackage

// File: rtl/wdt2_decode.sv
module wdt2_decode
  import wdt2_pkg::*;
#(
  parameter int NWORDS = 2
) (
  input  logic                rf_req,
  input  logic                rf_we,
  input  logic [FRAME_AW-1:0] rf_addr,
  input  logic                cf_req,
  input  logic                cf_we,
  input  logic [FRAME_AW-1:0] cf_addr,
  output logic                refresh,
  output logic                ctrl_wr,
  output logic                intv_wr,
  output logic [NWORDS-1:0]   dl_wr
);
  logic rf_write, cf_write;

  assign rf_write = rf_req & rf_we;
  assign cf_write = cf_req & cf_we;
  assign ctrl_wr  = cf_write & (cf_addr == A_CTRL);
  assign intv_wr  = cf_write & (cf_addr == A_INTERVAL);
  assign refresh  = ctrl_wr | (rf_write & (rf_addr == A_CTRL));

  for (genvar g = 0; g < NWORDS; g++) begin : g_dl_dec
    assign dl_wr[g] = cf_write & (cf_addr == A_DEADLINE + FRAME_AW'(g * 4));
  end
endmodule

// File: rtl/wdt2_deadline.sv
module wdt2_deadline #(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [CNT_W-1:0]                      sys_cnt,
  input  logic [DATA_W-1:0]                     interval,
  input  logic                                  refresh,
  input  logic                                  reload,
  input  logic [CNT_W/DATA_W-1:0]               dl_wr,
  input  logic [DATA_W-1:0]                     wdata,
  output logic [CNT_W-1:0]                      deadline,
  output logic                                  hit
);
  localparam int NWORDS = CNT_W / DATA_W;

  logic [CNT_W-1:0] next_dl;

  assign next_dl = sys_cnt + {{(CNT_W-DATA_W){1'b0}}, interval};
  assign hit     = (sys_cnt >= deadline);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deadline <= '0;
    end else if (refresh || reload) begin
      deadline <= next_dl;
    end else begin
      for (int i = 0; i < NWORDS; i++) begin
        if (dl_wr[i]) deadline[i*DATA_W +: DATA_W] <= wdata;
      end
    end
  end
endmodule

// File: rtl/wdt2_stage.sv
module wdt2_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic refresh,
  input  logic dl_write,
  input  logic hit,
  output logic warn_st,
  output logic rst_st,
  output logic reload
);
  logic expire;

  // a refresh or direct deadline write in the same cycle wins over expiry
  assign expire = en & hit & ~refresh & ~dl_write;
  assign reload = expire & ~warn_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_st <= 1'b0;
      rst_st  <= 1'b0;
    end else begin
      if (refresh)     warn_st <= 1'b0;
      else if (reload) warn_st <= 1'b1;
      if (expire && warn_st) rst_st <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt2_top.sv
module wdt2_top
  import wdt2_pkg::*;
#(
  parameter int          CNT_W   = 64,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] IMPL_ID = 32'h0102_043B,
  parameter logic [31:0] PART_ID = 32'h0000_5D20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    sys_cnt,
  input  logic                rf_req,
  input  logic                rf_we,
  input  logic [FRAME_AW-1:0] rf_addr,
  output logic [DATA_W-1:0]   rf_rdata,
  input  logic                cf_req,
  input  logic                cf_we,
  input  logic [FRAME_AW-1:0] cf_addr,
  input  logic [DATA_W-1:0]   cf_wdata,
  output logic [DATA_W-1:0]   cf_rdata,
  output logic                warn_irq,
  output logic                reset_req
);
  localparam int NWORDS = CNT_W / DATA_W;

  logic              refresh, ctrl_wr, intv_wr, reload, hit;
  logic [NWORDS-1:0] dl_wr;
  logic              dl_write;
  logic              en, warn_st, rst_st;
  logic [DATA_W-1:0] interval;
  logic [CNT_W-1:0]  deadline;

  wdt2_decode #(.NWORDS(NWORDS)) u_decode (
    .rf_req (rf_req),  .rf_we (rf_we), .rf_addr (rf_addr),
    .cf_req (cf_req),  .cf_we (cf_we), .cf_addr (cf_addr),
    .refresh(refresh), .ctrl_wr(ctrl_wr), .intv_wr(intv_wr), .dl_wr(dl_wr)
  );

  assign dl_write = |dl_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      interval <= '0;
    end else begin
      if (ctrl_wr) en       <= cf_wdata[B_EN];
      if (intv_wr) interval <= cf_wdata;
    end
  end

  wdt2_deadline #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_deadline (
    .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt), .interval(interval),
    .refresh(refresh), .reload(reload), .dl_wr(dl_wr), .wdata(cf_wdata),
    .deadline(deadline), .hit(hit)
  );

  wdt2_stage u_stage (
    .clk(clk), .rst_n(rst_n), .en(en), .refresh(refresh),
    .dl_write(dl_write), .hit(hit),
    .warn_st(warn_st), .rst_st(rst_st), .reload(reload)
  );

  assign warn_irq  = warn_st & en;
  assign reset_req = rst_st & en;

  always_comb begin
    rf_rdata = '0;
    if (rf_addr == A_IMPL) rf_rdata = DATA_W'(IMPL_ID);
    if (rf_addr == A_PART) rf_rdata = DATA_W'(PART_ID);
  end

  always_comb begin
    cf_rdata = '0;
    if (cf_addr == A_CTRL) begin
      cf_rdata[B_EN]   = en;
      cf_rdata[B_WARN] = warn_st;
      cf_rdata[B_RST]  = rst_st;
    end
    if (cf_addr == A_INTERVAL) cf_rdata = interval;
    if (cf_addr == A_IMPL)     cf_rdata = DATA_W'(IMPL_ID);
    if (cf_addr == A_PART)     cf_rdata = DATA_W'(PART_ID);
    for (int i = 0; i < NWORDS; i++) begin
      if (cf_addr == A_DEADLINE + FRAME_AW'(i * 4))
        cf_rdata = deadline[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/wdt2_checker.sv
module wdt2_checker #(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  sys_cnt,
  input logic              refresh,
  input logic              en,
  input logic              warn_st,
  input logic              rst_st,
  input logic [CNT_W-1:0]  deadline,
  input logic [DATA_W-1:0] interval
);
  p_refresh_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> deadline == $past(sys_cnt) + {{(CNT_W-DATA_W){1'b0}}, $past(interval)});

  p_warn_at_deadline_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_st) |-> $past(en && (sys_cnt >= deadline)));

  p_reset_after_warn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_st) |-> $past(warn_st));

  p_refresh_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> !warn_st);

  p_reset_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_st |=> rst_st);

  p_frozen_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !$rose(warn_st) && !$rose(rst_st));
endmodule

bind wdt2_top wdt2_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt), .refresh(refresh), .en(en),
  .warn_st(warn_st), .rst_st(rst_st), .deadline(deadline), .interval(interval)
);

// File: tb/wdt2_top_bench.sv
module wdt2_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IMPL = 32'h0102_043B;
  localparam logic [31:0] PART = 32'h0000_5D20;

  logic        clk = 0, rst_n = 0;
  logic [63:0] sys_cnt = '0;
  logic        rf_req = 0, rf_we = 0, cf_req = 0, cf_we = 0;
  logic [11:0] rf_addr = '0, cf_addr = '0;
  logic [31:0] cf_wdata = '0, rf_rdata, cf_rdata;
  logic        warn_irq, reset_req;
  int          n_vec = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt2_top u_wdt2_top (
    .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt),
    .rf_req(rf_req), .rf_we(rf_we), .rf_addr(rf_addr), .rf_rdata(rf_rdata),
    .cf_req(cf_req), .cf_we(cf_we), .cf_addr(cf_addr), .cf_wdata(cf_wdata),
    .cf_rdata(cf_rdata), .warn_irq(warn_irq), .reset_req(reset_req)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cf_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); cf_req = 1; cf_we = 1; cf_addr = a; cf_wdata = d;
    @(negedge clk); cf_req = 0; cf_we = 0;
  endtask

  task automatic rf_write(input logic [11:0] a);
    @(negedge clk); rf_req = 1; rf_we = 1; rf_addr = a;
    @(negedge clk); rf_req = 0; rf_we = 0;
  endtask

  task automatic cf_read(input logic [11:0] a, output logic [31:0] d);
    cf_addr = a; #1; d = cf_rdata;
  endtask

  task automatic tick(input logic [63:0] c);
    @(negedge clk); sys_cnt = c;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    cf_read(12'h000, d); chk("R1 ctrl", d, 0);
    cf_read(12'h008, d); chk("R1 interval", d, 0);
    cf_read(12'h010, d); chk("R1 deadline", d, 0);
    chk("R1 outputs", {warn_irq, reset_req}, 0);
  endtask

  task automatic t_ids;
    logic [31:0] d;
    cf_read(12'hFCC, d); chk("R10 cf impl", d, IMPL);
    cf_read(12'hFD0, d); chk("R10 cf part", d, PART);
    rf_addr = 12'hFCC; #1; chk("R10 rf impl", rf_rdata, IMPL);
    rf_addr = 12'hFD0; #1; chk("R10 rf part", rf_rdata, PART);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    cf_write(12'h008, 32'hCAFE_0123);
    cf_read(12'h008, d); chk("R2 interval rw", d, 32'hCAFE_0123);
    cf_write(12'h014, 32'h0000_0001);
    cf_write(12'h010, 32'h0000_0032);
    cf_read(12'h014, d); chk("R2 deadline hi", d, 1);
    cf_read(12'h010, d); chk("R2 deadline lo", d, 32'h32);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    tick(64'h3_0000_0000);
    chk("R9 no warn while off", warn_irq, 0);
    cf_read(12'h000, d); chk("R9 status while off", d, 0);
  endtask

  task automatic t_stage1;
    logic [31:0] d;
    cf_write(12'h008, 100);
    sys_cnt = 1000;
    cf_write(12'h000, 1);
    cf_read(12'h010, d); chk("R4 arm refresh lo", d, 1100);
    cf_read(12'h014, d); chk("R4 arm refresh hi", d, 0);
    tick(1099); chk("R5 before deadline", warn_irq, 0);
    tick(1100); chk("R5 at deadline irq", warn_irq, 1);
    cf_read(12'h000, d); chk("R5 status", d, 3);
    cf_read(12'h010, d); chk("R5 reload", d, 1200);
  endtask

  task automatic t_refresh_frame;
    logic [31:0] d;
    sys_cnt = 1150;
    rf_write(12'h000);
    chk("R7 irq cleared", warn_irq, 0);
    cf_read(12'h000, d); chk("R7 status", d, 1);
    cf_read(12'h010, d); chk("R3 refresh load", d, 1250);
    rf_write(12'h004);
    cf_read(12'h010, d); chk("R3 other offset no refresh", d, 1250);
  endtask

  task automatic t_direct_deadline;
    logic [31:0] d;
    cf_write(12'h010, 1180);
    tick(1179); chk("R2 direct before", warn_irq, 0);
    tick(1180); chk("R2 direct deadline fires", warn_irq, 1);
    sys_cnt = 1190; rf_write(12'h000);
    cf_read(12'h000, d); chk("R7 cleared again", d, 1);
  endtask

  task automatic t_two_stage;
    logic [31:0] d;
    sys_cnt = 1300;
    cf_write(12'h000, 32'h7);
    cf_read(12'h000, d); chk("R4 status bits not written", d, 1);
    cf_read(12'h010, d); chk("R4 ctrl write refresh", d, 1400);
    tick(1400); chk("R5 stage one", warn_irq, 1);
    tick(1499); chk("R6 before second deadline", reset_req, 0);
    tick(1500); chk("R6 reset at 2x interval", reset_req, 1);
    cf_read(12'h000, d); chk("R6 status", d, 7);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    rf_write(12'h000);
    cf_read(12'h000, d); chk("R8 sticky after refresh", d, 5);
    chk("R8 reset_req held", reset_req, 1);
    cf_write(12'h000, 0);
    cf_read(12'h000, d); chk("R8 sticky after disable", d, 4);
    chk("R9 outputs low when off", {warn_irq, reset_req}, 0);
    tick(64'hFFFF_0000);
    chk("R9 still low", {warn_irq, reset_req}, 0);
    cf_read(12'h000, d); chk("R9 no stage while off", d, 4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ids();
    t_regs();
    t_disabled();
    t_stage1();
    t_refresh_frame();
    t_direct_deadline();
    t_two_stage();
    t_sticky();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule